// File: doc/BRIEF.md
# Interrupt, Halt and Reset Sequencer

This block decides when a small 16-bit processor core leaves its normal instruction stream. There are three sources of such a change. The first is a reset, which is asynchronous and active low. The second is one of three interrupt request lines, each raised by a rising edge. The third is a halt input that parks the core. For each event the block drives a two-step handshake to the core. It first requests a push of the program counter. Once the push is acknowledged, it requests a vector load and presents the program-memory address that holds the new counter value. While an event is being dispatched, and while the core is halted, it also asserts two flags: one tells the core to substitute no-operations for fetched instructions, the other tells it to keep the program counter where it is.

Interrupt lines are synchronised, edge-detected and latched as pending. A per-line enable mask decides whether a pending line may be dispatched. Line 0 has the highest priority. Events are dispatched one at a time. Halt mode starts on a rising edge of the halt input. It ends only when an enabled interrupt is taken, so the core resumes after the halt point once the service routine returns.

Top module: `flow_event_seq`

## Requirements
- R1: While `rstN` is low, without waiting for a clock, `pushReq` and `vecReq` are 0 and `holdPc` and `insertNop` are 1. All pending interrupt requests are discarded.
- R2: On the first rising clock edge after `rstN` goes high, `pushReq` rises. After `pushAck`, a vector load is requested with `vecAddr` = 16'h0FFC.
- R3: A request on line n is recorded only on a rising edge of `irqIn[n]`. Holding the line high produces exactly one dispatch.
- R4: When several enabled lines are pending, the lowest-numbered line is dispatched first, then the next, in ascending index order.
- R5: The vector address for line n is 16'h1FFF minus n (line 0 = 1FFF, line 1 = 1FFE, line 2 = 1FFD). `vecAddr` is 0 whenever `vecReq` is low.
- R6: `pushReq` stays high until a clock edge that sees `pushAck`. `vecReq` is high from the next cycle and stays high until a clock edge that sees `vecAck`, after which it is low. The two requests are never high together.
- R7: A request arriving during a dispatch does not change the vector of that dispatch. It is dispatched afterwards.
- R8: A pending line whose `irqEnable` bit is 0 is not dispatched, but it stays pending. It is dispatched once its enable bit is set.
- R9: A rising edge on `haltIn` sets halt mode from the next cycle: `holdPc` and `insertNop` are 1. They remain 1 after `haltIn` falls.
- R10: Halt mode ends only when an enabled interrupt is taken. After that dispatch completes, `holdPc` and `insertNop` return to 0 even if `haltIn` is still high. A masked request does not end halt mode.
- R11: `holdPc` and `insertNop` are 1 throughout every push and vector-load phase, and 0 when idle and not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 3 | Interrupt request lines, rising-edge active, line 0 highest priority |
| irqEnable | input | 3 | Per-line dispatch enable mask |
| haltIn | input | 1 | Halt request, rising edge enters halt mode |
| pushAck | input | 1 | Core has pushed the program counter |
| vecAck | input | 1 | Core has loaded the new counter from the vector address |
| pushReq | output | 1 | Request to push the program counter |
| vecReq | output | 1 | Request to load the counter from `vecAddr` |
| vecAddr | output | 16 | Program-memory address holding the new counter, valid with `vecReq` |
| insertNop | output | 1 | Replace fetched instructions with no-operations |
| holdPc | output | 1 | Keep the program counter from advancing |

## Verification
The dispatch path is swept over all eight enable masks crossed with all seven non-empty sets of simultaneously raised lines. Each combination must yield exactly the enabled lines in ascending order, then silence, and after enabling all lines it must yield the remaining masked ones. This separates priority errors, wrong vector arithmetic and masked lines that are lost or leak through. Separate patterns cover the following:
- a line held high, which distinguishes edge detection from level detection;
- a higher-priority edge arriving mid-dispatch, which exposes a vector that changes during a dispatch;
- halt entry followed by a masked and then an enabled request;
- a halt input still high after service;
- asynchronous resets taken from idle, with requests pending, and in the middle of a push.

// File: rtl/fes_pkg.sv
package fes_pkg;

  // Widest line index carried in the strobe bundle (supports up to 16 lines).
  localparam int LINE_IDX_W = 4;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic                  takeIrq;    // an interrupt is taken this cycle
    logic                  loadVec;    // capture the vector address
    logic                  vecIsReset; // current event is the reset event
    logic                  clrPend;    // retire the pending bit of lineIdx
    logic [LINE_IDX_W-1:0] lineIdx;    // line owning the current event
  } seqStrobe_t;

endpackage

// File: rtl/fes_datapath.sv
module fes_datapath
  import fes_pkg::*;
#(
  parameter int              NUM_IRQ     = 3,
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] IRQ_VEC_TOP = 16'h1FFF,
  parameter logic [ADDR_W-1:0] RESET_VEC   = 16'h0FFC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic               haltIn,
  input  seqStrobe_t         strobe,
  output logic [NUM_IRQ-1:0] eligible,
  output logic               haltMode,
  output logic [ADDR_W-1:0]  vecAddrQ
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_IRQ-1:0] syncQ [SYNC_STAGES];
  logic [NUM_IRQ-1:0] edgePrev;
  logic [NUM_IRQ-1:0] irqRise;
  logic [NUM_IRQ-1:0] pend;
  logic [NUM_IRQ-1:0] clrMask;
  logic               haltPrev;
  logic               haltRise;

  // Synchroniser chain for the asynchronous request lines.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      edgePrev <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      edgePrev <= syncQ[LAST_STAGE];
    end
  end

  assign irqRise = syncQ[LAST_STAGE] & ~edgePrev;

  // Pending latches, one per line.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
      assign clrMask[gi] = strobe.clrPend && (strobe.lineIdx == LINE_IDX_W'(gi));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            pend[gi] <= 1'b0;
        else if (irqRise[gi]) pend[gi] <= 1'b1;
        else if (clrMask[gi]) pend[gi] <= 1'b0;
      end

      // R8: a pending line stays pending until its own vector load is acknowledged
      a_r8_pend_kept: assert property (@(posedge clk) disable iff (!rstN)
        (pend[gi] && !clrMask[gi]) |=> pend[gi]);
    end
  endgenerate

  assign eligible = pend & irqEnable;

  // Halt mode: entered on a rising halt edge, left when an interrupt is taken.
  assign haltRise = haltIn & ~haltPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltPrev <= 1'b0;
      haltMode <= 1'b0;
    end else begin
      haltPrev <= haltIn;
      if (strobe.takeIrq)  haltMode <= 1'b0;
      else if (haltRise)   haltMode <= 1'b1;
    end
  end

  // R10: halt mode only clears when an interrupt was taken
  a_r10_halt_exit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(haltMode) |-> $past(strobe.takeIrq));

  // Vector address register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               vecAddrQ <= '0;
    else if (strobe.loadVec) vecAddrQ <= strobe.vecIsReset ? RESET_VEC
                                       : IRQ_VEC_TOP - ADDR_W'(strobe.lineIdx);
  end

endmodule

// File: rtl/fes_control.sv
module fes_control
  import fes_pkg::*;
#(
  parameter int NUM_IRQ = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] eligible,
  input  logic               pushAck,
  input  logic               vecAck,
  output seqStrobe_t         strobe,
  output logic               pushReq,
  output logic               vecReq,
  output logic               busy
);

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PUSH  = 2'd2,
    ST_VEC   = 2'd3
  } seqState_t;

  seqState_t             state;
  logic                  srcReset;
  logic [LINE_IDX_W-1:0] lineQ;
  logic [LINE_IDX_W-1:0] pick;
  logic                  anyEligible;

  // Fixed priority: lowest index wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (eligible[i]) pick = LINE_IDX_W'(i);
  end

  assign anyEligible = |eligible;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RESET;
      srcReset <= 1'b1;
      lineQ    <= '0;
    end else begin
      unique case (state)
        ST_RESET: begin
          state    <= ST_PUSH;
          srcReset <= 1'b1;
        end
        ST_IDLE: if (anyEligible) begin
          state    <= ST_PUSH;
          srcReset <= 1'b0;
          lineQ    <= pick;
        end
        ST_PUSH: if (pushAck) state <= ST_VEC;
        ST_VEC:  if (vecAck)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.takeIrq    = (state == ST_IDLE) && anyEligible;
    strobe.loadVec    = (state == ST_PUSH) && pushAck;
    strobe.vecIsReset = srcReset;
    strobe.clrPend    = (state == ST_VEC) && vecAck && !srcReset;
    strobe.lineIdx    = lineQ;
  end

  assign pushReq = (state == ST_PUSH);
  assign vecReq  = (state == ST_VEC);
  assign busy    = (state != ST_IDLE);

  // R6: push request held until acknowledged
  a_r6_push_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !pushAck) |=> pushReq);

  // R6: acknowledged push is followed by a vector request
  a_r6_vec_follows: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && pushAck) |=> vecReq);

  // R6: vector request held until acknowledged, then dropped
  a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !vecAck) |=> vecReq);

  a_r6_vec_done: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && vecAck) |=> !vecReq);

  // R7: the line of an interrupt dispatch is frozen for its duration
  a_r7_line_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !srcReset) |-> $stable(lineQ));

endmodule

// File: rtl/flow_event_seq.sv
module flow_event_seq #(
  parameter int          NUM_IRQ     = 3,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] IRQ_VEC_TOP = 16'h1FFF,
  parameter logic [15:0] RESET_VEC   = 16'h0FFC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic               haltIn,
  input  logic               pushAck,
  input  logic               vecAck,
  output logic               pushReq,
  output logic               vecReq,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               insertNop,
  output logic               holdPc
);

  fes_pkg::seqStrobe_t strobe;
  logic [NUM_IRQ-1:0]  eligible;
  logic                haltMode;
  logic                busy;
  logic [ADDR_W-1:0]   vecAddrQ;

  fes_control #(.NUM_IRQ(NUM_IRQ)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .eligible (eligible),
    .pushAck  (pushAck),
    .vecAck   (vecAck),
    .strobe   (strobe),
    .pushReq  (pushReq),
    .vecReq   (vecReq),
    .busy     (busy)
  );

  fes_datapath #(
    .NUM_IRQ     (NUM_IRQ),
    .SYNC_STAGES (SYNC_STAGES),
    .ADDR_W      (ADDR_W),
    .IRQ_VEC_TOP (ADDR_W'(IRQ_VEC_TOP)),
    .RESET_VEC   (ADDR_W'(RESET_VEC))
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .irqEnable (irqEnable),
    .haltIn    (haltIn),
    .strobe    (strobe),
    .eligible  (eligible),
    .haltMode  (haltMode),
    .vecAddrQ  (vecAddrQ)
  );

  assign holdPc    = busy | haltMode;
  assign insertNop = busy | haltMode;
  assign vecAddr   = vecReq ? vecAddrQ : '0;

  // R11: core is frozen during every dispatch phase
  a_r11_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq || vecReq) |-> (holdPc && insertNop));

  // R6: the two requests are never raised together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pushReq, vecReq}));

endmodule

// File: tb/test_flow_event_seq.sv
module test_flow_event_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  irqIn = '0;
  logic [2:0]  irqEnable = '0;
  logic        haltIn = 1'b0;
  logic        pushAck = 1'b0;
  logic        vecAck = 1'b0;
  logic        pushReq, vecReq, insertNop, holdPc;
  logic [15:0] vecAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  flow_event_seq i_flow_event_seq (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .irqEnable(irqEnable),
    .haltIn(haltIn), .pushAck(pushAck), .vecAck(vecAck),
    .pushReq(pushReq), .vecReq(vecReq), .vecAddr(vecAddr),
    .insertNop(insertNop), .holdPc(holdPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitPush(input string req);
    bit seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pushReq) begin seen = 1; break; end
    end
    chk({req, " push raised"}, 32'(seen), 1);
  endtask

  task automatic finishService(input string req, input logic [15:0] expAddr);
    @(negedge clk);
    chk("R6 push held", 32'(pushReq), 1);
    chk("R11 frozen in push", 32'({holdPc, insertNop}), 3);
    pushAck = 1'b1;
    @(negedge clk);
    pushAck = 1'b0;
    chk("R6 vec after push", 32'({pushReq, vecReq}), 1);
    chk({req, " vector"}, 32'(vecAddr), 32'(expAddr));
    chk("R11 frozen in vec", 32'({holdPc, insertNop}), 3);
    vecAck = 1'b1;
    @(negedge clk);
    vecAck = 1'b0;
    chk("R6 vec dropped", 32'(vecReq), 0);
    chk("R5 addr idle zero", 32'(vecAddr), 0);
  endtask

  task automatic serviceOne(input string req, input logic [15:0] expAddr);
    waitPush(req);
    finishService(req, expAddr);
  endtask

  task automatic expectQuiet(input string req, input int n);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pushReq) seen = 1;
    end
    chk({req, " no dispatch"}, 32'(seen), 0);
  endtask

  task automatic fire(input logic [2:0] lines);
    @(negedge clk);
    irqIn = lines;
    repeat (3) @(negedge clk);
    irqIn = '0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state, checked without a clock edge
    #5;
    chk("R1 reset outputs", 32'({pushReq, vecReq, holdPc, insertNop}), 4'b0011);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 push after release", 32'(pushReq), 1);
    finishService("R2", 16'h0FFC);
    chk("R11 idle not frozen", 32'({holdPc, insertNop}), 0);

    // R4 R5 R8: sweep every mask against every set of lines
    for (int m = 0; m < 8; m++) begin
      for (int p = 1; p < 8; p++) begin
        irqEnable = 3'(m);
        fire(3'(p));
        for (int n = 0; n < 3; n++)
          if (p[n] && m[n]) serviceOne("R4", 16'h1FFF - 16'(n));
        expectQuiet("R8 masked", 8);
        irqEnable = 3'b111;
        for (int n = 0; n < 3; n++)
          if (p[n] && !m[n]) serviceOne("R8 released", 16'h1FFF - 16'(n));
        expectQuiet("R4 drained", 4);
      end
    end

    // R3: level held high yields one dispatch
    irqEnable = 3'b111;
    @(negedge clk);
    irqIn = 3'b010;
    serviceOne("R3", 16'h1FFE);
    expectQuiet("R3 level", 12);
    irqIn = '0;
    expectQuiet("R3 fall", 5);
    fire(3'b010);
    serviceOne("R3 second edge", 16'h1FFE);

    // R7: higher priority arrival mid-dispatch waits
    fire(3'b100);
    waitPush("R7");
    fire(3'b001);
    repeat (2) @(negedge clk);
    finishService("R7 current", 16'h1FFD);
    serviceOne("R7 queued", 16'h1FFF);

    // R9 R10: halt entry, masked request, enabled exit
    irqEnable = '0;
    chk("R9 idle baseline", 32'(holdPc), 0);
    @(negedge clk);
    haltIn = 1'b1;
    @(negedge clk);
    chk("R9 halt entered", 32'({holdPc, insertNop}), 3);
    haltIn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 halt kept", 32'({holdPc, insertNop}), 3);
    fire(3'b010);
    expectQuiet("R10 masked", 8);
    chk("R10 masked keeps halt", 32'(holdPc), 1);
    irqEnable = 3'b010;
    serviceOne("R10", 16'h1FFE);
    chk("R10 halt left", 32'({holdPc, insertNop}), 0);

    // R10: halt input still high after service
    irqEnable = 3'b111;
    @(negedge clk);
    haltIn = 1'b1;
    @(negedge clk);
    chk("R9 halt level", 32'(holdPc), 1);
    fire(3'b001);
    serviceOne("R10 held", 16'h1FFF);
    chk("R10 resume with halt high", 32'({holdPc, insertNop}), 0);
    haltIn = 1'b0;
    expectQuiet("R10 no reentry", 4);
    chk("R10 still running", 32'(holdPc), 0);

    // R1: reset discards pending requests
    irqEnable = '0;
    fire(3'b111);
    repeat (3) @(negedge clk);
    #3 rstN = 1'b0;
    #1 chk("R1 async reset", 32'({pushReq, vecReq, holdPc, insertNop}), 4'b0011);
    @(negedge clk);
    rstN = 1'b1;
    serviceOne("R2 again", 16'h0FFC);
    irqEnable = 3'b111;
    expectQuiet("R1 pending cleared", 10);

    // R1: reset in the middle of a push
    fire(3'b100);
    waitPush("R1 mid");
    #3 rstN = 1'b0;
    #1 chk("R1 mid push", 32'({pushReq, vecReq, holdPc}), 3'b001);
    @(negedge clk);
    rstN = 1'b1;
    serviceOne("R2 mid", 16'h0FFC);
    expectQuiet("R1 mid cleared", 10);

    finish();
  end

endmodule